// File: doc/BRIEF.md
# Self-Clearing Time-Counter Reset Control

This block pairs a clear-control register with two 16-bit time counters: one for discharge time and one for charge time. Each counter has an enable. When enabled, it advances once for every group of base ticks set by a prescaler. If a counter wraps past its top value, a sticky rate-status bit is set. From then on the counter runs from a slower, alternate prescale.

The host resets a counter by writing 1 to the matching bit of the clear register. Bit 0 controls the discharge counter and bit 1 controls the charge counter. Each bit is driven by its own small state machine with two states:

- `CLR_IDLE`: the bit reads 0.
- `CLR_ACTIVE`: the bit reads 1, and the counter, its prescaler and its rate-status bit are forced to zero.

The transitions are:

- **arm**: `CLR_IDLE` to `CLR_ACTIVE` on a write with the bit at 1.
- **finish**: `CLR_ACTIVE` to `CLR_IDLE` on the next clock when no new 1 is written.
- **rearm**: stay in `CLR_ACTIVE` when another 1 arrives.

Because the bit returns to 0 by itself, the host never needs a second write.

With the default parameters and a 32768 Hz base tick, the default prescale of 28800 gives one count per 0.8789 s.

Top module: `tc_clear_ctrl`

## Requirements
- R1: A write with wr_data bit i at 1 (bit 0 = discharge, bit 1 = charge) makes clr_bits[i] read 1 on the next cycle. On the cycle after that, the matching counter reads 0.
- R2: A clear bit reads 1 for exactly one cycle after its write and then returns to 0 with no further write.
- R3: A wr_data bit at 0 leaves its clear bit, counter and status unchanged. Several bits at 1 in one write all clear together.
- R4: After reset, or after a clear, an enabled counter advances by one per DEF_DIV tick pulses. A counter whose enable is low holds its value.
- R5: When a counter wraps from all ones to 0, its rate-status bit goes to 1. After that the counter advances by one per ALT_DIV tick pulses.
- R6: Clearing a counter also clears its rate-status bit, restores the DEF_DIV rate and restarts the prescaler from zero.
- R7: A tick that would increment a counter in the cycle its clear is carried out is discarded. The counter still reads 0.
- R8: After reset, all counters, status bits and clear bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write strobe for the clear register |
| wr_data | input | 2 | Clear request bits (bit 0 discharge, bit 1 charge) |
| tick | input | 1 | Base tick pulse feeding both prescalers |
| dsch_en | input | 1 | Discharge counter enable |
| chg_en | input | 1 | Charge counter enable |
| dsch_count | output | CNT_W | Discharge time count |
| chg_count | output | CNT_W | Charge time count |
| dsch_slow | output | 1 | Discharge rate-status bit |
| chg_slow | output | 1 | Charge rate-status bit |
| clr_bits | output | 2 | Clear register readback |

## Verification
A clear bit is due one cycle after its write edge. The zeroed counter and status bit are due one cycle after that. A count step is due at the clock edge that samples the last tick of a prescale group. The bench drives and samples on falling edges and checks each result at the first falling edge after the rising edge it is due at. For example, in the priority case the bench checks that the counter still reads 0 on the falling edge right after the clear cycle, and that two further ticks leave it at 0, which shows the prescaler restarted.

// File: rtl/tc_clear_pkg.sv
package tc_clear_pkg;
    localparam int unsigned TC_CHANNELS = 2;
    localparam int unsigned CH_DSCH     = 0;
    localparam int unsigned CH_CHG      = 1;

    typedef enum logic {
        CLR_IDLE   = 1'b0,
        CLR_ACTIVE = 1'b1
    } clr_state_t;
endpackage

// File: rtl/tc_clear_fsm.sv
module tc_clear_fsm
    import tc_clear_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req,
    output logic busy,
    output logic do_clear
);
    clr_state_t state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CLR_IDLE:   if (req) state_d = CLR_ACTIVE;              // arm
            CLR_ACTIVE: state_d = req ? CLR_ACTIVE : CLR_IDLE;      // rearm / finish
            default:    state_d = CLR_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= CLR_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        busy     = 1'b0;
        do_clear = 1'b0;
        unique case (state_q)
            CLR_IDLE:   ;
            CLR_ACTIVE: begin
                busy     = 1'b1;
                do_clear = 1'b1;
            end
            default:    ;
        endcase
    end
endmodule

// File: rtl/tc_rate_counter.sv
module tc_rate_counter #(
    parameter int unsigned CNT_W   = 16,
    parameter int unsigned DEF_DIV = 28800,
    parameter int unsigned ALT_DIV = 115200
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             en,
    input  logic             clear,
    output logic [CNT_W-1:0] count,
    output logic             slow
);
    localparam int unsigned MAX_DIV = (ALT_DIV > DEF_DIV) ? ALT_DIV : DEF_DIV;
    localparam int unsigned PW      = $clog2(MAX_DIV) + 1;
    localparam logic [PW-1:0] DEF_LAST = PW'(DEF_DIV - 1);
    localparam logic [PW-1:0] ALT_LAST = PW'(ALT_DIV - 1);

    logic [PW-1:0] presc_q;
    logic [PW-1:0] last;
    logic          advance;
    logic          step;

    assign last    = slow ? ALT_LAST : DEF_LAST;
    assign advance = tick && en && !clear;
    assign step    = advance && (presc_q >= last);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            presc_q <= '0;
            count   <= '0;
            slow    <= 1'b0;
        end else if (clear) begin
            presc_q <= '0;
            count   <= '0;
            slow    <= 1'b0;
        end else if (advance) begin
            if (step) begin
                presc_q <= '0;
                count   <= count + 1'b1;
                if (&count) slow <= 1'b1;
            end else begin
                presc_q <= presc_q + 1'b1;
            end
        end
    end
endmodule

// File: rtl/tc_clear_ctrl.sv
module tc_clear_ctrl
    import tc_clear_pkg::*;
#(
    parameter int unsigned CNT_W   = 16,
    parameter int unsigned DEF_DIV = 28800,
    parameter int unsigned ALT_DIV = 115200
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [1:0]       wr_data,
    input  logic             tick,
    input  logic             dsch_en,
    input  logic             chg_en,
    output logic [CNT_W-1:0] dsch_count,
    output logic [CNT_W-1:0] chg_count,
    output logic             dsch_slow,
    output logic             chg_slow,
    output logic [1:0]       clr_bits
);
    logic [TC_CHANNELS-1:0] en_vec;
    logic [TC_CHANNELS-1:0] slow_vec;
    logic [CNT_W-1:0]       cnt_arr [TC_CHANNELS];

    assign en_vec[CH_DSCH] = dsch_en;
    assign en_vec[CH_CHG]  = chg_en;

    for (genvar ch = 0; ch < TC_CHANNELS; ch++) begin : g_ch
        logic do_clear;

        tc_clear_fsm u_fsm (
            .clk      (clk),
            .rst_n    (rst_n),
            .req      (wr_en && wr_data[ch]),
            .busy     (clr_bits[ch]),
            .do_clear (do_clear)
        );

        tc_rate_counter #(
            .CNT_W   (CNT_W),
            .DEF_DIV (DEF_DIV),
            .ALT_DIV (ALT_DIV)
        ) u_cnt (
            .clk   (clk),
            .rst_n (rst_n),
            .tick  (tick),
            .en    (en_vec[ch]),
            .clear (do_clear),
            .count (cnt_arr[ch]),
            .slow  (slow_vec[ch])
        );
    end

    assign dsch_count = cnt_arr[CH_DSCH];
    assign chg_count  = cnt_arr[CH_CHG];
    assign dsch_slow  = slow_vec[CH_DSCH];
    assign chg_slow   = slow_vec[CH_CHG];
endmodule

// File: rtl/tc_clear_ctrl_checker.sv
module tc_clear_ctrl_checker #(
    parameter int unsigned CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_en,
    input logic [1:0]       wr_data,
    input logic             dsch_en,
    input logic             chg_en,
    input logic [CNT_W-1:0] dsch_count,
    input logic [CNT_W-1:0] chg_count,
    input logic             dsch_slow,
    input logic             chg_slow,
    input logic [1:0]       clr_bits
);
    a_r1_write_sets_bit0: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_data[0]) |=> clr_bits[0]);
    a_r1_write_sets_bit1: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_data[1]) |=> clr_bits[1]);
    a_r1_clear_zeroes_dsch: assert property (@(posedge clk) disable iff (!rst_n)
        clr_bits[0] |=> (dsch_count == '0));
    a_r1_clear_zeroes_chg: assert property (@(posedge clk) disable iff (!rst_n)
        clr_bits[1] |=> (chg_count == '0));
    a_r2_self_return_bit0: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_bits[0] && !(wr_en && wr_data[0])) |=> !clr_bits[0]);
    a_r2_self_return_bit1: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_bits[1] && !(wr_en && wr_data[1])) |=> !clr_bits[1]);
    a_r3_zero_write_idle0: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_bits[0] && !(wr_en && wr_data[0])) |=> !clr_bits[0]);
    a_r3_zero_write_idle1: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_bits[1] && !(wr_en && wr_data[1])) |=> !clr_bits[1]);
    a_r4_hold_dsch: assert property (@(posedge clk) disable iff (!rst_n)
        (!dsch_en && !clr_bits[0]) |=> $stable(dsch_count));
    a_r4_hold_chg: assert property (@(posedge clk) disable iff (!rst_n)
        (!chg_en && !clr_bits[1]) |=> $stable(chg_count));
    a_r4_step_dsch: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_bits[0] |=> (dsch_count == $past(dsch_count) ||
                          dsch_count == CNT_W'($past(dsch_count) + 1'b1)));
    a_r5_slow_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (chg_slow && !clr_bits[1]) |=> chg_slow);
    a_r6_clear_status_dsch: assert property (@(posedge clk) disable iff (!rst_n)
        clr_bits[0] |=> !dsch_slow);
    a_r6_clear_status_chg: assert property (@(posedge clk) disable iff (!rst_n)
        clr_bits[1] |=> !chg_slow);
endmodule

bind tc_clear_ctrl tc_clear_ctrl_checker #(.CNT_W(CNT_W)) u_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .wr_data    (wr_data),
    .dsch_en    (dsch_en),
    .chg_en     (chg_en),
    .dsch_count (dsch_count),
    .chg_count  (chg_count),
    .dsch_slow  (dsch_slow),
    .chg_slow   (chg_slow),
    .clr_bits   (clr_bits)
);

// File: tb/tc_clear_ctrl_bench.sv
`timescale 1ns/1ps
module tc_clear_ctrl_bench;
    localparam int unsigned CNT_W   = 8;
    localparam int unsigned DEF_DIV = 3;
    localparam int unsigned ALT_DIV = 7;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             wr_en = 1'b0;
    logic [1:0]       wr_data = '0;
    logic             tick = 1'b0;
    logic             dsch_en = 1'b0;
    logic             chg_en = 1'b0;
    logic [CNT_W-1:0] dsch_count, chg_count;
    logic             dsch_slow, chg_slow;
    logic [1:0]       clr_bits;

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    tc_clear_ctrl #(.CNT_W(CNT_W), .DEF_DIV(DEF_DIV), .ALT_DIV(ALT_DIV)) u_tc_clear_ctrl (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .tick(tick),
        .dsch_en(dsch_en), .chg_en(chg_en), .dsch_count(dsch_count), .chg_count(chg_count),
        .dsch_slow(dsch_slow), .chg_slow(chg_slow), .clr_bits(clr_bits)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic pulse_ticks(input int n);
        for (int i = 0; i < n; i++) begin
            tick = 1'b1;
            @(negedge clk);
            tick = 1'b0;
            @(negedge clk);
        end
    endtask

    task automatic write_clr(input logic [1:0] d);
        wr_en   = 1'b1;
        wr_data = d;
        @(negedge clk);
        wr_en   = 1'b0;
        wr_data = '0;
    endtask

    task automatic t_reset();
        chk("R8", "dsch_count", dsch_count, 0);
        chk("R8", "chg_count", chg_count, 0);
        chk("R8", "slow bits", {dsch_slow, chg_slow}, 0);
        chk("R8", "clr_bits", clr_bits, 0);
    endtask

    task automatic t_default_rate();
        dsch_en = 1'b1;
        pulse_ticks(8);
        chk("R4", "dsch after 8 ticks", dsch_count, 2);
        pulse_ticks(1);
        chk("R4", "dsch after 9 ticks", dsch_count, 3);
        chk("R4", "chg held while disabled", chg_count, 0);
    endtask

    task automatic t_clear_single();
        write_clr(2'b01);
        chk("R1", "clr_bits after write", clr_bits, 1);
        @(negedge clk);
        chk("R2", "clr_bits self return", clr_bits, 0);
        chk("R1", "dsch zeroed", dsch_count, 0);
        chk("R1", "chg untouched", chg_count, 0);
    endtask

    task automatic t_write_zero();
        pulse_ticks(3);
        chk("R4", "dsch after 3 ticks", dsch_count, 1);
        write_clr(2'b00);
        chk("R3", "clr_bits after zero write", clr_bits, 0);
        @(negedge clk);
        chk("R3", "dsch kept after zero write", dsch_count, 1);
    endtask

    task automatic t_clear_both();
        chg_en = 1'b1;
        pulse_ticks(6);
        chk("R4", "dsch before joint clear", dsch_count, 3);
        chk("R4", "chg before joint clear", chg_count, 2);
        write_clr(2'b11);
        chk("R3", "both clr bits set", clr_bits, 3);
        @(negedge clk);
        chk("R3", "both clr bits back", clr_bits, 0);
        chk("R3", "dsch zeroed jointly", dsch_count, 0);
        chk("R3", "chg zeroed jointly", chg_count, 0);
        chg_en = 1'b0;
    endtask

    task automatic t_priority();
        pulse_ticks(5);
        chk("R7", "dsch before priority clear", dsch_count, 1);
        wr_en = 1'b1;
        wr_data = 2'b01;
        @(negedge clk);
        wr_en = 1'b0;
        wr_data = '0;
        tick = 1'b1;
        chk("R7", "clr bit during clear cycle", clr_bits, 1);
        @(negedge clk);
        tick = 1'b0;
        chk("R7", "tick dropped in clear cycle", dsch_count, 0);
        @(negedge clk);
        pulse_ticks(2);
        chk("R6", "prescaler restarted", dsch_count, 0);
        pulse_ticks(1);
        chk("R6", "first step after clear", dsch_count, 1);
        dsch_en = 1'b0;
    endtask

    task automatic t_wrap();
        chg_en = 1'b1;
        pulse_ticks(255 * DEF_DIV + DEF_DIV - 1);
        chk("R5", "chg at top", chg_count, 255);
        chk("R5", "chg status before wrap", chg_slow, 0);
        pulse_ticks(1);
        chk("R5", "chg wrapped", chg_count, 0);
        chk("R5", "chg status after wrap", chg_slow, 1);
        pulse_ticks(ALT_DIV - 1);
        chk("R5", "slow rate not yet stepped", chg_count, 0);
        pulse_ticks(1);
        chk("R5", "slow rate step", chg_count, 1);
        chk("R4", "dsch held while disabled", dsch_count, 1);
    endtask

    task automatic t_restore();
        write_clr(2'b10);
        @(negedge clk);
        chk("R6", "chg status cleared", chg_slow, 0);
        chk("R6", "chg zeroed", chg_count, 0);
        pulse_ticks(DEF_DIV);
        chk("R6", "default rate restored", chg_count, 1);
    endtask

    initial begin
        #2_000_000;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_default_rate();
        t_clear_single();
        t_write_zero();
        t_clear_both();
        t_priority();
        t_wrap();
        t_restore();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule